// File: doc/BRIEF.md
# Leveled Interrupt Status and Mask Controller

This block gathers thirteen level-sensitive interrupt lines from peripherals into a 32-bit pending register. Each line owns a fixed bit in that register. A 32-bit enable register sits beside it, and the block reduces the enabled pending bits to a 3-bit CPU priority level. The sources fall into three priority groups: level 3 for the slow peripherals, level 5 for the serial port, and level 6 for sound and the DMA engines. The output carries the highest group that holds at least one enabled pending source.

Software reads and writes both registers through a simple 32-bit register port. A separate byte-write strobe carries the SCSI control byte, and one bit of that byte drives the SCSI DMA pending bit directly. Acknowledge cycles and vector generation belong to other logic.

Top module: `irq_level_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending register, the enable register and `ipl` all clear to zero.
- R2: Source index i of `src_lvl` maps to pending bit as follows: 0→2, 1→3, 2→5, 3→7, 4→9, 5→10, 6→12, 7→17, 8→21, 9→23, 10→26, 11→27, 12→28. A source line sampled high at a clock edge sets its bit at that edge.
- R3: A source line sampled low at an edge, after being high at the previous edge, clears its pending bit at that edge.
- R4: A write with `reg_addr` = 0x7000 loads all 32 pending bits, and a write with 0x7800 loads all 32 enable bits. `reg_rdata` combinationally returns the pending register for 0x7000, the enable register for 0x7800, and zero for any other address.
- R5: A line that is high overrides a software write of 0 to its pending bit in the same cycle. A line that has been low for two edges leaves the written value in place.
- R6: A strobe on `scsi_ctl_we` loads pending bit 26 from bit 4 (value 0x10) of `scsi_ctl_data`. This byte takes priority over a register write to that bit, and source line 10 takes priority over the byte.
- R7: Bits 2, 3, 5, 7, 9, 10 and 12 form group 3. Bit 17 forms group 5. Bits 21, 23, 26, 27 and 28 form group 6.
- R8: `ipl` is 6 if any group-6 bit is both pending and enabled. Otherwise it is 5 if bit 17 is both pending and enabled, otherwise 3 if any group-3 bit is both pending and enabled, and otherwise 0.
- R9: `ipl` is registered, so it follows the pending and enable registers one clock later.
- R10: Pending bits that belong to no source keep a value written by software and never raise `ipl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 13 | Level-sensitive source lines, index order as in R2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| scsi_ctl_we | input | 1 | SCSI control byte write strobe |
| scsi_ctl_data | input | 8 | SCSI control byte |
| ipl | output | 3 | Registered CPU priority level (0, 3, 5 or 6) |

## Verification
Several properties are checked on every cycle:
- a high line sets its bit on the next cycle, and a falling line clears it;
- the SCSI byte lands in bit 26 when source line 10 is idle;
- the enable register takes written data;
- `ipl` only ever takes a legal level and follows the highest enabled pending group one clock later.

Other behaviour only the bench scenarios can show: the exact source-to-bit map, the read mux including zero reads at unused offsets, the way a software write competes with live lines, and the hold of software-written bits that belong to no source.

// File: rtl/irq_pkg.sv
// Package: shared constants for the leveled interrupt controller.
// Holds the source-to-bit map, the priority group of each source,
// register offsets and helpers that derive the group bit masks.
package irq_pkg;

    localparam int DATA_W      = 32;
    localparam int NUM_SRC     = 13;
    localparam int ADDR_W      = 16;
    localparam int LVL_W       = 3;

    localparam logic [ADDR_W-1:0] STAT_OFS = 16'h7000;
    localparam logic [ADDR_W-1:0] MASK_OFS = 16'h7800;

    localparam int SCSI_DMA_POS = 26;
    localparam int SCSI_DMA_SRC = 10;
    localparam int SCTL_DMA_BIT = 4;

    // Pending bit owned by each source index.
    localparam int SRC_POS [NUM_SRC] = '{2, 3, 5, 7, 9, 10, 12, 17, 21, 23, 26, 27, 28};
    // CPU priority group of each source index.
    localparam int SRC_GRP [NUM_SRC] = '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

    // Build the bit mask of every pending bit that belongs to group grp.
    function automatic logic [DATA_W-1:0] grp_mask(input int grp);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (SRC_GRP[i] == grp) m[SRC_POS[i]] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_status_reg.sv
// Module: pending-bit register.
// Each source line forces its bit high while asserted and clears it on
// the edge where it is first seen low. Software writes and the SCSI
// control byte load bits otherwise. Assumes lines are synchronous to clk.
module irq_status_reg
    import irq_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            sw_we,
    input  logic [W-1:0]    sw_data,
    input  logic            sctl_we,
    input  logic            sctl_val,
    output logic [W-1:0]    stat_q
);

    logic [NSRC-1:0] src_q;
    logic [W-1:0]    stat_d;

    // Remember each line's level at the previous edge for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_lvl;
    end

    // Merge writes and line events; lines have the final say.
    always_comb begin
        stat_d = stat_q;
        if (sw_we)   stat_d = sw_data;
        if (sctl_we) stat_d[SCSI_DMA_POS] = sctl_val;
        for (int i = 0; i < NSRC; i++) begin
            if (src_lvl[i])    stat_d[SRC_POS[i]] = 1'b1;
            else if (src_q[i]) stat_d[SRC_POS[i]] = 1'b0;
        end
    end

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        // R2
        line_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            src_lvl[g] |=> stat_q[SRC_POS[g]]);
        // R3
        fall_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_q[g] && !src_lvl[g]) |=> !stat_q[SRC_POS[g]]);
    end

    // R6
    scsi_byte_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sctl_we && !src_lvl[SCSI_DMA_SRC] && !src_q[SCSI_DMA_SRC])
        |=> stat_q[SCSI_DMA_POS] == $past(sctl_val));

endmodule

// File: rtl/irq_regif.sv
// Module: register access. Decodes offsets, holds the enable register
// and returns read data combinationally. Assumes one access per cycle.
module irq_regif
    import irq_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    input  logic [W-1:0]  stat_q,
    output logic          stat_we,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  reg_rdata
);

    // Write strobe toward the pending register.
    always_comb stat_we = reg_we && (reg_addr == STAT_OFS);

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 mask_q <= '0;
        else if (reg_we && (reg_addr == MASK_OFS))  mask_q <= reg_wdata;
    end

    // Read mux; unused offsets return zero.
    always_comb begin
        if (reg_addr == STAT_OFS)      reg_rdata = stat_q;
        else if (reg_addr == MASK_OFS) reg_rdata = mask_q;
        else                           reg_rdata = '0;
    end

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == MASK_OFS) |=> mask_q == $past(reg_wdata));

endmodule

// File: rtl/irq_level_enc.sv
// Module: priority encoder. Reduces pending AND enable to the highest
// group level and registers it. Assumes groups are 6 > 5 > 3.
module irq_level_enc
    import irq_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  stat_q,
    input  logic [W-1:0]  mask_q,
    output logic [LW-1:0] ipl_q
);

    localparam logic [W-1:0] G6 = grp_mask(6);
    localparam logic [W-1:0] G5 = grp_mask(5);
    localparam logic [W-1:0] G3 = grp_mask(3);

    logic [W-1:0]  live;
    logic [LW-1:0] ipl_d;

    // Pick the highest group with an enabled pending bit.
    always_comb begin
        live = stat_q & mask_q;
        if (|(live & G6))      ipl_d = LW'(6);
        else if (|(live & G5)) ipl_d = LW'(5);
        else if (|(live & G3)) ipl_d = LW'(3);
        else                   ipl_d = '0;
    end

    // Output level register.
    always_ff @(posedge clk) begin
        if (!rst_n) ipl_q <= '0;
        else        ipl_q <= ipl_d;
    end

    // R8
    legal_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_q == 0) || (ipl_q == 3) || (ipl_q == 5) || (ipl_q == 6));
    // R9
    top_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & mask_q & G6)) |=> ipl_q == LW'(6));
    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & mask_q & (G6 | G5 | G3)) == '0) |=> ipl_q == '0);

endmodule

// File: rtl/irq_level_ctrl.sv
// Module: top of the leveled interrupt controller. Wires the register
// port, the pending register and the level encoder together. Assumes
// all inputs are synchronous to clk.
module irq_level_ctrl
    import irq_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int NSRC = NUM_SRC,
    parameter int AW   = ADDR_W,
    parameter int LW   = LVL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [W-1:0]    reg_wdata,
    output logic [W-1:0]    reg_rdata,
    input  logic            scsi_ctl_we,
    input  logic [7:0]      scsi_ctl_data,
    output logic [LW-1:0]   ipl
);

    logic          stat_we;
    logic [W-1:0]  stat_q;
    logic [W-1:0]  mask_q;

    irq_regif #(.W(W), .AW(AW)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .stat_q    (stat_q),
        .stat_we   (stat_we),
        .mask_q    (mask_q),
        .reg_rdata (reg_rdata)
    );

    irq_status_reg #(.W(W), .NSRC(NSRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .sw_we    (stat_we),
        .sw_data  (reg_wdata),
        .sctl_we  (scsi_ctl_we),
        .sctl_val (scsi_ctl_data[SCTL_DMA_BIT]),
        .stat_q   (stat_q)
    );

    irq_level_enc #(.W(W), .LW(LW)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_q (stat_q),
        .mask_q (mask_q),
        .ipl_q  (ipl)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ipl == '0 && stat_q == '0 && mask_q == '0));

endmodule

// File: tb/irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module irq_level_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src_lvl = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scsi_ctl_we = 1'b0;
    logic [7:0]  scsi_ctl_data = '0;
    logic [2:0]  ipl;

    int n_chk = 0;
    int n_err = 0;

    // bench model
    logic [31:0] m_stat = '0, m_mask = '0;
    logic [2:0]  m_ipl = '0;
    logic [12:0] m_prev = '0;
    logic [31:0] n_stat, n_mask;
    logic [2:0]  n_ipl;
    logic [12:0] n_prev;

    localparam int POS [13] = '{2, 3, 5, 7, 9, 10, 12, 17, 21, 23, 26, 27, 28};
    localparam logic [31:0] M6 = (32'h1 << 21) | (32'h1 << 23) | (32'h7 << 26);
    localparam logic [31:0] M5 = 32'h1 << 17;
    localparam logic [31:0] M3 = 32'h0000_16AC;

    always #4 clk = ~clk;

    irq_level_ctrl u_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scsi_ctl_we(scsi_ctl_we), .scsi_ctl_data(scsi_ctl_data), .ipl(ipl)
    );

    function automatic logic [2:0] exp_level(input logic [31:0] s, input logic [31:0] m);
        logic [31:0] l;
        l = s & m;
        if (|(l & M6)) return 3'd6;
        if (|(l & M5)) return 3'd5;
        if (|(l & M3)) return 3'd3;
        return 3'd0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        if (a == 16'h7000) return m_stat;
        if (a == 16'h7800) return m_mask;
        return 32'h0;
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (ipl !== m_ipl) begin
            n_err++;
            $display("FAIL %s ipl actual %0d expected %0d", tag, ipl, m_ipl);
        end
        n_chk++;
        if (reg_rdata !== exp_read(reg_addr)) begin
            n_err++;
            $display("FAIL %s rdata@%h actual %h expected %h", tag, reg_addr,
                     reg_rdata, exp_read(reg_addr));
        end
    endtask

    // One cycle: compare at the falling edge, drive, advance the model.
    task automatic cyc(input string tag, input logic rn, input logic [12:0] src,
                       input logic we, input logic [15:0] a, input logic [31:0] wd,
                       input logic swe, input logic [7:0] sd);
        @(negedge clk);
        check(tag);
        rst_n = rn; src_lvl = src; reg_we = we; reg_addr = a; reg_wdata = wd;
        scsi_ctl_we = swe; scsi_ctl_data = sd;
        if (!rn) begin
            n_stat = '0; n_mask = '0; n_ipl = '0; n_prev = '0;
        end else begin
            n_ipl  = exp_level(m_stat, m_mask);
            n_mask = (we && a == 16'h7800) ? wd : m_mask;
            n_stat = (we && a == 16'h7000) ? wd : m_stat;
            if (swe) n_stat[26] = sd[4];
            for (int i = 0; i < 13; i++) begin
                if (src[i])         n_stat[POS[i]] = 1'b1;
                else if (m_prev[i]) n_stat[POS[i]] = 1'b0;
            end
            n_prev = src;
        end
        @(posedge clk);
        m_stat = n_stat; m_mask = n_mask; m_ipl = n_ipl; m_prev = n_prev;
    endtask

    task automatic idle(input string tag, input logic [12:0] src, input logic [15:0] a);
        cyc(tag, 1'b1, src, 1'b0, a, 32'h0, 1'b0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        // R1 reset state
        repeat (3) cyc("R1", 1'b0, 13'h1FFF, 1'b1, 16'h7800, 32'hFFFF_FFFF, 1'b1, 8'hFF);
        idle("R1", 13'h0, 16'h7000);
        idle("R1", 13'h0, 16'h7800);
        idle("R1", 13'h0, 16'h7000);
        // R4 enable all, read back, unused offset reads zero
        cyc("R4", 1'b1, 13'h0, 1'b1, 16'h7800, 32'hFFFF_FFFF, 1'b0, 8'h00);
        idle("R4", 13'h0, 16'h7800);
        idle("R4", 13'h0, 16'h1234);
        // R2 R3 R7 each source alone, then release
        for (int i = 0; i < 13; i++) begin
            idle("R2", 13'h1 << i, 16'h7000);
            idle("R7", 13'h1 << i, 16'h7000);
            idle("R7", 13'h1 << i, 16'h7000);
            idle("R3", 13'h0, 16'h7000);
            idle("R3", 13'h0, 16'h7000);
        end
        // R9 latency: source rises, level lags a clock
        idle("R9", 13'h0001, 16'h7000);
        idle("R9", 13'h0001, 16'h7000);
        idle("R9", 13'h0000, 16'h7000);
        idle("R9", 13'h0000, 16'h7000);
        // R8 priority: group 3 and 6 together, then mask group 6
        idle("R8", 13'h1001, 16'h7000);
        idle("R8", 13'h1001, 16'h7000);
        cyc("R8", 1'b1, 13'h1001, 1'b1, 16'h7800, ~M6, 1'b0, 8'h00);
        idle("R8", 13'h1001, 16'h7800);
        idle("R8", 13'h1081, 16'h7000);
        idle("R8", 13'h1081, 16'h7000);
        cyc("R8", 1'b1, 13'h1081, 1'b1, 16'h7800, 32'h0, 1'b0, 8'h00);
        idle("R8", 13'h1081, 16'h7000);
        idle("R8", 13'h0000, 16'h7000);
        cyc("R8", 1'b1, 13'h0, 1'b1, 16'h7800, 32'hFFFF_FFFF, 1'b0, 8'h00);
        // R5 write of zero loses to a live line, kept for an idle one
        idle("R5", 13'h0004, 16'h7000);
        cyc("R5", 1'b1, 13'h0004, 1'b1, 16'h7000, 32'h0, 1'b0, 8'h00);
        idle("R5", 13'h0004, 16'h7000);
        idle("R5", 13'h0000, 16'h7000);
        idle("R5", 13'h0000, 16'h7000);
        cyc("R5", 1'b1, 13'h0, 1'b1, 16'h7000, 32'h0000_0004, 1'b0, 8'h00);
        idle("R5", 13'h0, 16'h7000);
        idle("R5", 13'h0, 16'h7000);
        cyc("R5", 1'b1, 13'h0, 1'b1, 16'h7000, 32'h0, 1'b0, 8'h00);
        // R6 SCSI byte drives bit 26 and beats a register write
        cyc("R6", 1'b1, 13'h0, 1'b0, 16'h7000, 32'h0, 1'b1, 8'h10);
        idle("R6", 13'h0, 16'h7000);
        idle("R6", 13'h0, 16'h7000);
        cyc("R6", 1'b1, 13'h0, 1'b1, 16'h7000, 32'hFFFF_FFFF, 1'b1, 8'hEF);
        idle("R6", 13'h0, 16'h7000);
        idle("R6", 13'h0, 16'h7000);
        cyc("R6", 1'b1, 13'h0, 1'b1, 16'h7000, 32'h0, 1'b0, 8'h00);
        idle("R6", 13'h0, 16'h7000);
        // R10 unassigned bits hold and raise nothing
        cyc("R10", 1'b1, 13'h0, 1'b1, 16'h7000, 32'hE051_4953, 1'b0, 8'h00);
        idle("R10", 13'h0, 16'h7000);
        idle("R10", 13'h0, 16'h7000);
        idle("R10", 13'h0, 16'h7000);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a;
            logic [12:0] s;
            int sel;
            sel = $urandom_range(0, 2);
            a = (sel == 0) ? 16'h7000 : (sel == 1) ? 16'h7800 : 16'h0040;
            s = ($urandom_range(0, 3) == 0) ? 13'($urandom) : src_lvl;
            cyc("R8", 1'b1, s, ($urandom_range(0, 3) == 0), a, $urandom,
                ($urandom_range(0, 7) == 0), 8'($urandom));
        end
        @(negedge clk);
        check("R9");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule